// File: doc/BRIEF.md
# Receive Polarity Auto-Correction Unit

This block sits on the receive side of a 10 Mb/s twisted-pair port, after the pulse qualifier. It watches qualified link pulses and decides whether the receive pair is wired with its two conductors swapped. When it concludes that the pair is reversed, it inverts every bit of the received data word before passing it on. A status bit reports the polarity that is currently applied.

The qualifier reports pulses one per cycle. Each report carries a polarity flag and a kind: a plain link pulse, or one clock pulse inside a fast link pulse burst. A separate strobe marks the end of each burst. Reversal can be declared in two ways. The first is a run of consecutive inverted link pulses. The second is one burst in which every clock pulse is inverted. Detection runs only when the port is in 10BASE-T operation or in auto-negotiation.

An auto-correct disable input hands the polarity bit to software. While that input is low, software writes to the bit are ignored. While it is high, the bit is a force control: writing 1 inverts the data and writing 0 does not.

Top module: `rx_polarity_fixer`

## Requirements
- R1: After reset, `rev_pol` is 0, `rx_data_out` is 0, and no partial pulse run or burst history is retained.
- R2: With detection active and auto-correction enabled, the RUN_LEN-th consecutive inverted link pulse (`pulse_kind`=0, `pulse_inverted`=1; RUN_LEN defaults to 8) sets `rev_pol` to 1 on the following cycle. Fewer than RUN_LEN inverted link pulses leave it unchanged.
- R3: A correctly polarized link pulse (`pulse_inverted`=0) restarts the inverted-link-pulse run at zero.
- R4: At `burst_end`, a burst whose clock pulses (`pulse_kind`=1) were all inverted sets `rev_pol` to 1. A burst with mixed polarity, or one with no clock pulses, changes nothing. A clock pulse reported in the same cycle as `burst_end` belongs to the ending burst.
- R5: Once `rev_pol` is set, it holds until reset, until RUN_LEN consecutive correct link pulses arrive, or until a burst whose clock pulses were all correct ends. Either of the last two returns it to 0.
- R6: Detection is active only while `mode_10bt` or `mode_aneg` is 1. Outside these modes, pulses and burst ends have no effect, and any partial run or burst history is discarded.
- R7: `rx_data_out` equals the previous cycle's `rx_data_in` with every bit XORed with the previous cycle's `rev_pol`.
- R8: While `ac_disable` is 1, detection verdicts have no effect. A write (`sw_wr_en`=1) loads `sw_wr_data` into `rev_pol` on the next cycle.
- R9: While `ac_disable` is 0, software writes have no effect on `rev_pol`.
- R10: If a reversal verdict and a correct-polarity verdict complete in the same cycle, `rev_pol` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_10bt | input | 1 | Port is in 10BASE-T operation |
| mode_aneg | input | 1 | Auto-negotiation is running |
| pulse_valid | input | 1 | A qualified pulse is reported this cycle |
| pulse_kind | input | 1 | 0 = plain link pulse, 1 = clock pulse within a burst |
| pulse_inverted | input | 1 | Reported pulse arrived with inverted polarity |
| burst_end | input | 1 | The current fast link pulse burst has finished |
| ac_disable | input | 1 | 1 turns automatic correction off and enables software control |
| sw_wr_en | input | 1 | Software write strobe for the polarity bit |
| sw_wr_data | input | 1 | Value written to the polarity bit |
| rx_data_in | input | DATA_W | Received data before correction |
| rx_data_out | output | DATA_W | Polarity-corrected data, one cycle later |
| rev_pol | output | 1 | Applied polarity: 1 = reversed |

## Verification
The detector is driven with unbroken runs of inverted link pulses, both one pulse short of the threshold and exactly at it. This separates the threshold count from an off-by-one error. Runs that are broken by a single correct pulse show whether the count restarts or merely pauses. Bursts are sent all inverted, all correct, mixed, and empty, and a burst's final pulse is placed in the same cycle as its end strobe; together these separate the all-pulses rule from an any-pulse rule and from a rule that drops the final pulse. Other patterns are repeated with the port outside both modes, with the mode dropped halfway through a run, and with auto-correction switched off and on around software writes. These show whether stale history or writes leak through.

// File: rtl/rxpol_pkg.sv
// Shared types for the receive polarity auto-correction unit.
// Assumes one qualified pulse at most per cycle.
package rxpol_pkg;

    // Kind of a qualified pulse reported by the front end
    typedef enum logic {
        PK_LINK      = 1'b0,
        PK_BURST_CLK = 1'b1
    } pulse_kind_e;

    // Verdict produced by a detection path in one cycle
    typedef struct packed {
        logic to_reversed;
        logic to_normal;
    } verdict_t;

endpackage

// File: rtl/rxpol_link_run.sv
// Tracks runs of consecutive plain link pulses of equal polarity.
// It issues a reversal verdict once RUN_LEN inverted pulses arrive back
// to back, and a normal verdict once RUN_LEN correct pulses do.
// A pulse of the opposite polarity restarts the other run.
// Assumes pulse_hit is high only for a valid plain link pulse. When
// enable is low, both runs are cleared and no verdict is given.
module rxpol_link_run
    import rxpol_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     pulse_hit,
    input  logic     pulse_inv,
    output verdict_t verdict
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

    logic [CW-1:0] inv_run_q, ok_run_q;
    logic [CW-1:0] inv_run_d, ok_run_d;
    logic [CW-1:0] inv_inc, ok_inc;

    // Saturating increments of both runs
    always_comb begin
        inv_inc = (inv_run_q == RUN_MAX) ? RUN_MAX : inv_run_q + CW'(1);
        ok_inc  = (ok_run_q  == RUN_MAX) ? RUN_MAX : ok_run_q  + CW'(1);
    end

    // Next run lengths for this cycle's pulse
    always_comb begin
        inv_run_d = inv_run_q;
        ok_run_d  = ok_run_q;
        if (!enable) begin
            inv_run_d = '0;
            ok_run_d  = '0;
        end else if (pulse_hit) begin
            if (pulse_inv) begin
                inv_run_d = inv_inc;
                ok_run_d  = '0;
            end else begin
                ok_run_d  = ok_inc;
                inv_run_d = '0;
            end
        end
    end

    // Verdict on the pulse that completes or extends a full run
    always_comb begin
        verdict.to_reversed = enable && pulse_hit && pulse_inv  && (inv_run_d == RUN_MAX);
        verdict.to_normal   = enable && pulse_hit && !pulse_inv && (ok_run_d  == RUN_MAX);
    end

    // Run length registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_run_q <= '0;
            ok_run_q  <= '0;
        end else begin
            inv_run_q <= inv_run_d;
            ok_run_q  <= ok_run_d;
        end
    end

endmodule

// File: rtl/rxpol_burst_judge.sv
// Judges each fast link pulse burst as a whole. It records whether any
// inverted or any correct clock pulse was seen. At the end strobe, it gives
// a reversal verdict if only inverted pulses were seen and a normal verdict
// if only correct ones were. Mixed and empty bursts give no verdict.
// Assumes a clock pulse reported with the end strobe belongs to that burst.
module rxpol_burst_judge
    import rxpol_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     clk_hit,
    input  logic     pulse_inv,
    input  logic     burst_end,
    output verdict_t verdict
);
    logic saw_inv_q, saw_ok_q;
    logic saw_inv_now, saw_ok_now;

    // History including the pulse of this cycle
    always_comb begin
        saw_inv_now = saw_inv_q || (clk_hit && pulse_inv);
        saw_ok_now  = saw_ok_q  || (clk_hit && !pulse_inv);
    end

    // Burst verdict at the end strobe
    always_comb begin
        verdict.to_reversed = enable && burst_end && saw_inv_now && !saw_ok_now;
        verdict.to_normal   = enable && burst_end && saw_ok_now  && !saw_inv_now;
    end

    // Burst history, cleared at each burst end or when detection stops
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || burst_end) begin
            saw_inv_q <= 1'b0;
            saw_ok_q  <= 1'b0;
        end else begin
            saw_inv_q <= saw_inv_now;
            saw_ok_q  <= saw_ok_now;
        end
    end

endmodule

// File: rtl/rxpol_state.sv
// Holds the applied polarity bit. With auto-correction on, the bit follows
// the combined verdicts of both detection paths; opposing verdicts in one
// cycle cancel. With auto-correction off, it follows software writes only.
module rxpol_state
    import rxpol_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ac_disable,
    input  logic     sw_wr_en,
    input  logic     sw_wr_data,
    input  verdict_t link_v,
    input  verdict_t burst_v,
    output logic     pol
);
    logic want_rev, want_norm;
    logic pol_d;

    // Merge the two detection paths
    always_comb begin
        want_rev  = link_v.to_reversed || burst_v.to_reversed;
        want_norm = link_v.to_normal   || burst_v.to_normal;
    end

    // Select the source of the next polarity value
    always_comb begin
        pol_d = pol;
        if (ac_disable) begin
            if (sw_wr_en) pol_d = sw_wr_data;
        end else if (want_rev && !want_norm) begin
            pol_d = 1'b1;
        end else if (want_norm && !want_rev) begin
            pol_d = 1'b0;
        end
    end

    // Polarity register
    always_ff @(posedge clk) begin
        if (!rst_n) pol <= 1'b0;
        else        pol <= pol_d;
    end

endmodule

// File: rtl/rx_polarity_fixer.sv
// Receive polarity auto-correction unit, top level. It routes qualified
// pulses to the link-run and burst detectors, keeps the applied polarity,
// and registers the data word XORed with that polarity.
// Assumes the inputs are synchronous to clk and at most one pulse per cycle.
module rx_polarity_fixer
    import rxpol_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter int RUN_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_10bt,
    input  logic              mode_aneg,
    input  logic              pulse_valid,
    input  logic              pulse_kind,
    input  logic              pulse_inverted,
    input  logic              burst_end,
    input  logic              ac_disable,
    input  logic              sw_wr_en,
    input  logic              sw_wr_data,
    input  logic [DATA_W-1:0] rx_data_in,
    output logic [DATA_W-1:0] rx_data_out,
    output logic              rev_pol
);
    logic     detect_on;
    logic     link_hit, clk_hit;
    verdict_t link_v, burst_v;

    // Decode the pulse kind and the detection window
    always_comb begin
        detect_on = mode_10bt || mode_aneg;
        link_hit  = pulse_valid && (pulse_kind_e'(pulse_kind) == PK_LINK);
        clk_hit   = pulse_valid && (pulse_kind_e'(pulse_kind) == PK_BURST_CLK);
    end

    rxpol_link_run #(.RUN_LEN(RUN_LEN)) u_link_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (detect_on),
        .pulse_hit (link_hit),
        .pulse_inv (pulse_inverted),
        .verdict   (link_v)
    );

    rxpol_burst_judge u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (detect_on),
        .clk_hit   (clk_hit),
        .pulse_inv (pulse_inverted),
        .burst_end (burst_end),
        .verdict   (burst_v)
    );

    rxpol_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .ac_disable (ac_disable),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_data (sw_wr_data),
        .link_v     (link_v),
        .burst_v    (burst_v),
        .pol        (rev_pol)
    );

    // Per-bit corrected data register
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) rx_data_out[b] <= 1'b0;
            else        rx_data_out[b] <= rx_data_in[b] ^ rev_pol;
        end
    end

endmodule

// File: rtl/rxpol_checker.sv
// Temporal checks on the ports of rx_polarity_fixer, attached by bind.
module rxpol_checker #(
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_10bt,
    input logic              mode_aneg,
    input logic              pulse_valid,
    input logic              burst_end,
    input logic              ac_disable,
    input logic              sw_wr_en,
    input logic              sw_wr_data,
    input logic [DATA_W-1:0] rx_data_in,
    input logic [DATA_W-1:0] rx_data_out,
    input logic              rev_pol
);
    // R7: output word is last cycle's input XOR last cycle's polarity
    assert_data_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rx_data_out == ($past(rx_data_in) ^ {DATA_W{$past(rev_pol)}}));

    // R8: a software write lands when auto-correction is off
    assert_sw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_disable && sw_wr_en) |=> rev_pol == $past(sw_wr_data));

    // R8: without a write, the bit holds when auto-correction is off
    assert_sw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ac_disable && !sw_wr_en) |=> $stable(rev_pol));

    // R6: outside the detection modes, auto mode never changes the bit
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ac_disable && !mode_10bt && !mode_aneg) |=> $stable(rev_pol));

    // R9: in auto mode, with no pulse and no burst end, writes do nothing
    assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ac_disable && !pulse_valid && !burst_end) |=> $stable(rev_pol));

endmodule

bind rx_polarity_fixer rxpol_checker #(.DATA_W(DATA_W)) u_rxpol_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_10bt   (mode_10bt),
    .mode_aneg   (mode_aneg),
    .pulse_valid (pulse_valid),
    .burst_end   (burst_end),
    .ac_disable  (ac_disable),
    .sw_wr_en    (sw_wr_en),
    .sw_wr_data  (sw_wr_data),
    .rx_data_in  (rx_data_in),
    .rx_data_out (rx_data_out),
    .rev_pol     (rev_pol)
);

// File: tb/test_rx_polarity_fixer.sv
`timescale 1ns/1ps
module test_rx_polarity_fixer;
    localparam int W   = 4;
    localparam int RUN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_10bt = 1'b0, mode_aneg = 1'b0;
    logic pulse_valid = 1'b0, pulse_kind = 1'b0, pulse_inverted = 1'b0, burst_end = 1'b0;
    logic ac_disable = 1'b0, sw_wr_en = 1'b0, sw_wr_data = 1'b0;
    logic [W-1:0] rx_data_in = '0;
    logic [W-1:0] rx_data_out;
    logic rev_pol;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA5;

    // Reference model state
    int m_inv = 0, m_ok = 0;
    bit m_binv = 0, m_bok = 0;
    bit m_pol = 0;
    logic [W-1:0] m_out = '0;

    always #2.5 clk = ~clk;

    rx_polarity_fixer #(.DATA_W(W), .RUN_LEN(RUN)) i_rx_polarity_fixer (
        .clk(clk), .rst_n(rst_n), .mode_10bt(mode_10bt), .mode_aneg(mode_aneg),
        .pulse_valid(pulse_valid), .pulse_kind(pulse_kind),
        .pulse_inverted(pulse_inverted), .burst_end(burst_end),
        .ac_disable(ac_disable), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .rx_data_in(rx_data_in), .rx_data_out(rx_data_out), .rev_pol(rev_pol)
    );

    // Behavioural model, written from the requirements
    always @(posedge clk) begin
        bit rev, fwd, bi, bo;
        rev = 0; fwd = 0;
        if (!rst_n) begin
            m_inv = 0; m_ok = 0; m_binv = 0; m_bok = 0; m_pol = 0; m_out = '0;
        end else begin
            if (mode_10bt || mode_aneg) begin
                if (pulse_valid && !pulse_kind) begin
                    if (pulse_inverted) begin
                        m_inv = (m_inv < RUN) ? m_inv + 1 : RUN; m_ok = 0;
                        if (m_inv >= RUN) rev = 1;
                    end else begin
                        m_ok = (m_ok < RUN) ? m_ok + 1 : RUN; m_inv = 0;
                        if (m_ok >= RUN) fwd = 1;
                    end
                end
                bi = m_binv; bo = m_bok;
                if (pulse_valid && pulse_kind) begin
                    if (pulse_inverted) bi = 1; else bo = 1;
                end
                if (burst_end) begin
                    if (bi && !bo) rev = 1;
                    if (bo && !bi) fwd = 1;
                    m_binv = 0; m_bok = 0;
                end else begin
                    m_binv = bi; m_bok = bo;
                end
            end else begin
                m_inv = 0; m_ok = 0; m_binv = 0; m_bok = 0;
            end
            m_out = rx_data_in ^ {W{m_pol}};
            if (ac_disable) begin
                if (sw_wr_en) m_pol = sw_wr_data;
            end else if (rev && !fwd) m_pol = 1;
            else if (fwd && !rev) m_pol = 0;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual cycles=%0d expected < 20000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic compare(input string tag);
        n_cmp++;
        if (rev_pol !== m_pol || rx_data_out !== m_out) begin
            n_bad++;
            $display("FAIL %s: actual pol=%0b data=%h expected pol=%0b data=%h",
                     tag, rev_pol, rx_data_out, m_pol, m_out);
        end
    endtask

    task automatic expect_pol(input string tag, input bit exp);
        n_cmp++;
        if (rev_pol !== exp) begin
            n_bad++;
            $display("FAIL %s: actual rev_pol=%0b expected %0b", tag, rev_pol, exp);
        end
    endtask

    // One cycle: apply inputs, clock, compare with the model
    task automatic step(input string tag, input bit pv, input bit pk, input bit pi, input bit be);
        pulse_valid = pv; pulse_kind = pk; pulse_inverted = pi; burst_end = be;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rx_data_in = lfsr[W-1:0];
        @(posedge clk); #1;
        compare(tag);
        pulse_valid = 0; burst_end = 0; sw_wr_en = 0;
    endtask

    task automatic links(input string tag, input int n, input bit inv);
        for (int i = 0; i < n; i++) begin
            step(tag, 1, 0, inv, 0);
            step(tag, 0, 0, 0, 0);
        end
    endtask

    task automatic burst(input string tag, input int n, input bit inv);
        for (int i = 0; i < n; i++) step(tag, 1, 1, inv, 0);
        step(tag, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) begin @(posedge clk); #1; end
        compare("R1 reset");
        expect_pol("R1 reset", 0);
        rst_n = 1;
        for (int i = 0; i < 6; i++) step("R7 passthrough", 0, 0, 0, 0);

        // R6: inverted pulses outside both modes are ignored
        links("R6 inactive", RUN + 2, 1);
        burst("R6 inactive burst", 4, 1);
        expect_pol("R6 inactive", 0);

        mode_10bt = 1;
        // R3: a correct pulse restarts the run
        links("R3 run", RUN - 1, 1);
        links("R3 break", 1, 0);
        links("R3 run", RUN - 1, 1);
        expect_pol("R3 restart", 0);
        links("R2 threshold", 1, 1);
        expect_pol("R2 threshold", 1);
        for (int i = 0; i < 5; i++) step("R7 inverted data", 0, 0, 0, 0);

        // R5: correct run clears
        links("R5 clear", RUN - 1, 0);
        expect_pol("R5 hold", 1);
        links("R5 clear", 1, 0);
        expect_pol("R5 clear", 0);

        // R6: dropping the mode discards a partial run
        links("R6 partial", RUN - 1, 1);
        mode_10bt = 0;
        step("R6 drop", 0, 0, 0, 0);
        mode_aneg = 1;
        links("R6 resume", 1, 1);
        expect_pol("R6 discarded", 0);

        // R4: burst judgements
        burst("R4 mixed", 0, 1);
        step("R4 mixed", 1, 1, 1, 0);
        step("R4 mixed", 1, 1, 0, 0);
        step("R4 mixed", 1, 1, 1, 1);
        expect_pol("R4 mixed ignored", 0);
        step("R4 empty", 0, 0, 0, 1);
        expect_pol("R4 empty ignored", 0);
        step("R4 last with end", 1, 1, 1, 0);
        step("R4 last with end", 1, 1, 1, 1);
        expect_pol("R4 all inverted", 1);
        step("R5 mixed", 1, 1, 0, 0);
        step("R5 mixed", 1, 1, 1, 1);
        expect_pol("R5 mixed keeps", 1);
        burst("R5 correct burst", 3, 0);
        expect_pol("R5 correct burst", 0);
        burst("R4 inverted burst", 5, 1);
        expect_pol("R4 inverted burst", 1);

        // R10: opposing verdicts in one cycle
        links("R10 setup", RUN - 1, 0);
        step("R10 setup", 1, 1, 1, 0);
        step("R10 setup", 0, 0, 0, 0);
        step("R10 clash", 1, 0, 0, 1);
        expect_pol("R10 clash holds", 1);

        // R9: writes ignored in auto mode
        sw_wr_data = 0; sw_wr_en = 1;
        step("R9 write", 0, 0, 0, 0);
        step("R9 write", 0, 0, 0, 0);
        expect_pol("R9 write ignored", 1);

        // R8: software control
        ac_disable = 1;
        sw_wr_data = 0; sw_wr_en = 1;
        step("R8 write0", 0, 0, 0, 0);
        step("R8 write0", 0, 0, 0, 0);
        expect_pol("R8 write 0", 0);
        links("R8 verdict ignored", RUN + 1, 1);
        burst("R8 verdict ignored", 3, 1);
        expect_pol("R8 verdict ignored", 0);
        sw_wr_data = 1; sw_wr_en = 1;
        step("R8 write1", 0, 0, 0, 0);
        expect_pol("R8 force", 1);
        for (int i = 0; i < 4; i++) step("R8 R7 forced data", 0, 0, 0, 0);
        links("R8 verdict ignored", RUN + 1, 0);
        expect_pol("R8 hold", 1);
        ac_disable = 0;
        links("R5 after handback", RUN, 0);
        expect_pol("R5 after handback", 0);

        // R1: reset mid-run
        links("R1 pre", RUN - 1, 1);
        rst_n = 0;
        step("R1 reset", 0, 0, 0, 0);
        rst_n = 1;
        links("R1 post", 1, 1);
        expect_pol("R1 run cleared", 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule